// File: doc/BRIEF.md
# Sample Smoother with Baseline-Derived Threshold

This block conditions one channel of a 14-bit unsigned ADC sample stream. Every accepted sample passes through a three-tap smoothing filter that weights the centre sample three times as heavily as each of its neighbours and divides the weighted sum by five. Because the filter needs the sample that follows the one it centres on, each smoothed value appears one accepted sample late.

Alongside the filter, the block keeps a trigger threshold for later stages. On request it gathers sixteen consecutive accepted samples from the channel's baseline. It then takes their mean and adds the block's spread (largest minus smallest sample). The result is written into a threshold register in a single step. A mode input chooses whether the block presents this derived value or a value written from outside. Sample deserialisation and the trigger decision itself belong to neighbouring blocks.

Top module: `smooth_thresh_top`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `smp_out_vld` is 0. In derived mode (`thr_sel_manual` = 0), `thr_level` reads 16383 until the first threshold calculation completes.
- R2: For accepted samples a, b, c in that order, the smoothed value for b is the integer quotient (a + 3·b + c + 2) / 5, which rounds to nearest. It appears on `smp_out` with `smp_out_vld` = 1 in the cycle after c is presented with `smp_in_vld` = 1.
- R3: Only cycles with `smp_in_vld` = 1 advance the filter history. The first two accepted samples after reset produce no output. After those, each accepted sample produces exactly one single-cycle output pulse. Cycles without `smp_in_vld` produce none.
- R4: The smoothed output never exceeds 16383. A run of samples at 16383 gives exactly 16383.
- R5: A `thr_recalc` pulse while the calculator is idle starts a block made of the next 16 accepted samples, counted from the following cycle. In the cycle after the 16th of them, the derived threshold becomes floor(sum / 16) + (max − min) over that block.
- R6: While a block is being gathered, the derived threshold keeps its previous value. A `thr_recalc` pulse during gathering is ignored and does not restart the block.
- R7: If mean plus spread exceeds 16383, the derived threshold is 16383.
- R8: With `thr_sel_manual` = 1, `thr_level` equals `thr_manual` in the same cycle. With 0, it shows the derived threshold. Time spent in manual mode leaves the derived value unchanged.
- R9: Samples presented with `smp_in_vld` = 0 do not enter the threshold statistics, whatever their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_in_vld | input | 1 | Sample strobe |
| smp_in | input | 14 | Unsigned ADC code |
| thr_sel_manual | input | 1 | 1 selects the external threshold, 0 the derived one |
| thr_manual | input | 14 | Externally written threshold |
| thr_recalc | input | 1 | Request to gather a new baseline block |
| smp_out_vld | output | 1 | Smoothed sample strobe |
| smp_out | output | 14 | Smoothed sample |
| thr_level | output | 14 | Threshold in use |

## Verification
A smoothed value is due one cycle after the strobe of the sample that follows its centre. A derived threshold is due one cycle after the strobe of the 16th block sample. The manual selection reaches `thr_level` in the same cycle. The bench keeps a behavioural model that is advanced at each rising edge from the inputs presented for that edge. At the following falling edge it compares the strobe, sample and threshold against that model, so every result is sampled in the cycle it is due and never across an edge. Named checks at the block boundaries (cold start, full-scale input, saturated threshold, ignored requests, invalid-strobe garbage) add fixed expected values worked out by hand.

// File: rtl/smth_pkg.sv
package smth_pkg;

  typedef enum logic {
    ST_IDLE    = 1'b0,
    ST_COLLECT = 1'b1
  } stat_state_e;

endpackage

// File: rtl/smth_fir3.sv
module smth_fir3 #(
  parameter int DATA_W      = 14,
  parameter int RECIP_SHIFT = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_sample,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_sample
);

  localparam int TAPS   = 2;
  localparam int SUM_W  = DATA_W + 3;
  localparam int PROD_W = SUM_W + RECIP_SHIFT + 1;
  localparam logic [PROD_W-1:0] RECIP    = PROD_W'(((64'd1 << RECIP_SHIFT) + 64'd4) / 64'd5);
  localparam logic [PROD_W-1:0] HALF     = PROD_W'(64'd1 << (RECIP_SHIFT - 1));
  localparam logic [PROD_W-1:0] CODE_MAX = PROD_W'((64'd1 << DATA_W) - 64'd1);

  // tap_q[0] holds x(n), tap_q[1] holds x(n-1); the incoming sample is x(n+1)
  logic [DATA_W-1:0] tap_q [TAPS];
  logic [DATA_W-1:0] tap_d [TAPS];

  generate
    for (genvar g = 0; g < TAPS; g++) begin : g_tap
      if (g == 0) begin : g_head
        assign tap_d[g] = in_sample;
      end else begin : g_chain
        assign tap_d[g] = tap_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          tap_q[g] <= '0;
        end else if (in_valid) begin
          tap_q[g] <= tap_d[g];
        end
      end
    end
  endgenerate

  logic [1:0]        fill_q, fill_d;
  logic              hist_full;
  logic [SUM_W-1:0]  wsum;
  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] quo;
  logic [DATA_W-1:0] y_d;
  logic              ov_d;

  always_comb begin
    hist_full = (fill_q == 2'd2);
    fill_d    = fill_q;
    if (in_valid && !hist_full) begin
      fill_d = fill_q + 2'd1;
    end
    wsum = SUM_W'(tap_q[1]) + SUM_W'({tap_q[0], 1'b0}) + SUM_W'(tap_q[0])
         + SUM_W'(in_sample);
    prod = (PROD_W'(wsum) * RECIP) + HALF;
    quo  = prod >> RECIP_SHIFT;
    if (quo > CODE_MAX) begin
      y_d = '1;
    end else begin
      y_d = quo[DATA_W-1:0];
    end
    ov_d = in_valid && hist_full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q     <= '0;
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      fill_q    <= fill_d;
      out_valid <= ov_d;
      if (ov_d) begin
        out_sample <= y_d;
      end
    end
  end

  AST_OUT_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid)) else $error("output without input"); // R3

  AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> $stable(out_sample)) else $error("output moved"); // R3

endmodule

// File: rtl/smth_base_stats.sv
module smth_base_stats
  import smth_pkg::*;
#(
  parameter int DATA_W     = 14,
  parameter int BLOCK_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_sample,
  input  logic              recalc_req,
  output logic [DATA_W-1:0] thr_auto,
  output logic              busy,
  output logic              done
);

  localparam int ACC_W = DATA_W + BLOCK_LOG2;
  localparam int TOT_W = ACC_W + 1;
  localparam logic [BLOCK_LOG2-1:0] LAST_IDX = '1;
  localparam logic [TOT_W-1:0] CODE_MAX = TOT_W'((64'd1 << DATA_W) - 64'd1);

  stat_state_e           state_q, state_d;
  logic [BLOCK_LOG2-1:0] cnt_q, cnt_d;
  logic [ACC_W-1:0]      acc_q, acc_d, acc_sum;
  logic [DATA_W-1:0]     mn_q, mn_d, mn_n;
  logic [DATA_W-1:0]     mx_q, mx_d, mx_n;
  logic [DATA_W-1:0]     thr_q, thr_d;
  logic [TOT_W-1:0]      total;
  logic                  done_c;

  always_comb begin
    acc_sum = acc_q + ACC_W'(in_sample);
    mn_n    = (in_sample < mn_q) ? in_sample : mn_q;
    mx_n    = (in_sample > mx_q) ? in_sample : mx_q;
    total   = TOT_W'(acc_sum >> BLOCK_LOG2) + TOT_W'(mx_n - mn_n);

    state_d = state_q;
    cnt_d   = cnt_q;
    acc_d   = acc_q;
    mn_d    = mn_q;
    mx_d    = mx_q;
    thr_d   = thr_q;
    done_c  = 1'b0;

    case (state_q)
      ST_IDLE: begin
        if (recalc_req) begin
          state_d = ST_COLLECT;
          cnt_d   = '0;
          acc_d   = '0;
          mn_d    = '1;
          mx_d    = '0;
        end
      end
      default: begin
        if (in_valid) begin
          acc_d = acc_sum;
          mn_d  = mn_n;
          mx_d  = mx_n;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST_IDX) begin
            state_d = ST_IDLE;
            done_c  = 1'b1;
            thr_d   = (total > CODE_MAX) ? '1 : total[DATA_W-1:0];
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      acc_q   <= '0;
      mn_q    <= '1;
      mx_q    <= '0;
      thr_q   <= '1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      acc_q   <= acc_d;
      mn_q    <= mn_d;
      mx_q    <= mx_d;
      thr_q   <= thr_d;
    end
  end

  assign thr_auto = thr_q;
  assign busy     = (state_q == ST_COLLECT);
  assign done     = done_c;

  AST_THR_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> $stable(thr_q)) else $error("threshold moved"); // R6

  AST_REQ_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && recalc_req && !in_valid) |=> (busy && $stable(cnt_q))) else $error("restart"); // R6

  AST_FINISH_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(in_valid) && $past(cnt_q) == LAST_IDX)) else $error("early end"); // R5

  AST_STATS_SKIP_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !in_valid) |=> ($stable(acc_q) && $stable(mn_q) && $stable(mx_q))) else $error("stat moved"); // R9

endmodule

// File: rtl/smth_thr_sel.sv
module smth_thr_sel #(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_manual,
  input  logic [DATA_W-1:0] thr_manual,
  input  logic [DATA_W-1:0] thr_auto,
  input  logic              auto_done,
  output logic [DATA_W-1:0] thr_level
);

  always_comb begin
    if (sel_manual) begin
      thr_level = thr_manual;
    end else begin
      thr_level = thr_auto;
    end
  end

  AST_AUTO_CHANGES_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_manual && !$past(sel_manual) && thr_level != $past(thr_level)) |-> $past(auto_done))
    else $error("derived threshold changed without a finished block"); // R8

endmodule

// File: rtl/smooth_thresh_top.sv
module smooth_thresh_top #(
  parameter int DATA_W      = 14,
  parameter int BLOCK_LOG2  = 4,
  parameter int RECIP_SHIFT = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_in_vld,
  input  logic [DATA_W-1:0] smp_in,
  input  logic              thr_sel_manual,
  input  logic [DATA_W-1:0] thr_manual,
  input  logic              thr_recalc,
  output logic              smp_out_vld,
  output logic [DATA_W-1:0] smp_out,
  output logic [DATA_W-1:0] thr_level
);

  logic [DATA_W-1:0] thr_auto;
  logic              stat_busy;
  logic              stat_done;

  smth_fir3 #(
    .DATA_W      (DATA_W),
    .RECIP_SHIFT (RECIP_SHIFT)
  ) u_fir (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (smp_in_vld),
    .in_sample  (smp_in),
    .out_valid  (smp_out_vld),
    .out_sample (smp_out)
  );

  smth_base_stats #(
    .DATA_W     (DATA_W),
    .BLOCK_LOG2 (BLOCK_LOG2)
  ) u_stats (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (smp_in_vld),
    .in_sample  (smp_in),
    .recalc_req (thr_recalc),
    .thr_auto   (thr_auto),
    .busy       (stat_busy),
    .done       (stat_done)
  );

  smth_thr_sel #(
    .DATA_W (DATA_W)
  ) u_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_manual (thr_sel_manual),
    .thr_manual (thr_manual),
    .thr_auto   (thr_auto),
    .auto_done  (stat_done),
    .thr_level  (thr_level)
  );

  AST_FRESH_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(rst_n)) |-> !smp_out_vld) else $error("output right after reset"); // R1

  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_busy) |-> $past(stat_done)) else $error("block ended without done"); // R5

endmodule

// File: tb/tb_smooth_thresh_top.sv
module tb_smooth_thresh_top;

  localparam int MAXC = 16383;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        smp_in_vld;
  logic [13:0] smp_in;
  logic        thr_sel_manual;
  logic [13:0] thr_manual;
  logic        thr_recalc;
  logic        smp_out_vld;
  logic [13:0] smp_out;
  logic [13:0] thr_level;

  always #10 clk = ~clk;

  smooth_thresh_top dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .smp_in_vld     (smp_in_vld),
    .smp_in         (smp_in),
    .thr_sel_manual (thr_sel_manual),
    .thr_manual     (thr_manual),
    .thr_recalc     (thr_recalc),
    .smp_out_vld    (smp_out_vld),
    .smp_out        (smp_out),
    .thr_level      (thr_level)
  );

  int checks = 0;
  int failures = 0;
  string cur_tag = "R1";

  // behavioural reference model
  int hist[$];
  int m_ov, m_os, m_thr;
  int m_busy, m_cnt, m_sum, m_mn, m_mx;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist.delete();
      m_ov = 0; m_os = 0; m_thr = MAXC; m_busy = 0; m_cnt = 0;
      m_sum = 0; m_mn = MAXC; m_mx = 0;
    end else begin
      m_ov = 0;
      if (smp_in_vld) begin
        if (hist.size() == 2) begin
          int v;
          v = (hist[0] + 3 * hist[1] + int'(smp_in) + 2) / 5;
          m_os = (v > MAXC) ? MAXC : v;
          m_ov = 1;
          void'(hist.pop_front());
        end
        hist.push_back(int'(smp_in));
      end
      if (m_busy != 0) begin
        if (smp_in_vld) begin
          int t;
          m_sum += int'(smp_in);
          if (int'(smp_in) < m_mn) m_mn = int'(smp_in);
          if (int'(smp_in) > m_mx) m_mx = int'(smp_in);
          m_cnt++;
          if (m_cnt == 16) begin
            t = m_sum / 16 + (m_mx - m_mn);
            m_thr = (t > MAXC) ? MAXC : t;
            m_busy = 0;
          end
        end
      end else if (thr_recalc) begin
        m_busy = 1; m_cnt = 0; m_sum = 0; m_mn = MAXC; m_mx = 0;
      end
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_now();
    int exp_thr;
    exp_thr = thr_sel_manual ? int'(thr_manual) : m_thr;
    chk(cur_tag, "smp_out_vld", int'(smp_out_vld), m_ov);
    if (m_ov != 0) chk(cur_tag, "smp_out", int'(smp_out), m_os);
    chk(cur_tag, "thr_level", int'(thr_level), exp_thr);
  endtask

  // at a falling edge: compare, drive, advance to next falling edge
  task automatic cyc(input logic v, input int s, input logic req);
    compare_now();
    smp_in_vld = v;
    smp_in     = 14'(s);
    thr_recalc = req;
    @(negedge clk);
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    rst_n = 1'b0; smp_in_vld = 1'b0; smp_in = '0;
    thr_sel_manual = 1'b0; thr_manual = '0; thr_recalc = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "reset smp_out_vld", int'(smp_out_vld), 0);
    chk("R1", "reset thr_level", int'(thr_level), MAXC);
    rst_n = 1'b1;
    cyc(0, 0, 0);
    chk("R1", "first cycle smp_out_vld", int'(smp_out_vld), 0);

    // R3: two samples silent, gaps skipped
    cur_tag = "R3";
    cyc(1, 10, 0);
    cyc(0, 9000, 0);
    cyc(1, 20, 0);
    chk("R3", "silent after two samples", int'(smp_out_vld), 0);
    cyc(0, 7777, 0);
    cyc(1, 40, 0);
    // R2: (10 + 60 + 40 + 2)/5 = 22
    chk("R2", "first smoothed value", int'(smp_out), 22);
    chk("R2", "first smoothed strobe", int'(smp_out_vld), 1);
    cyc(0, 0, 0);
    chk("R3", "single pulse", int'(smp_out_vld), 0);

    // R2: rounding cases (0,0,3) -> 1 ; (0,0,2) -> 0
    cur_tag = "R2";
    cyc(1, 0, 0); cyc(1, 0, 0); cyc(1, 3, 0);
    chk("R2", "round up 0.6", int'(smp_out), 1);
    cyc(1, 0, 0); cyc(1, 0, 0); cyc(1, 2, 0);
    chk("R2", "round down 0.4", int'(smp_out), 0);

    // R2: random stream with random gaps
    for (int i = 0; i < 300; i++) begin
      cyc(logic'($urandom_range(0, 3) != 0), int'($urandom_range(0, MAXC)), 0);
    end

    // R4: full scale
    cur_tag = "R4";
    for (int i = 0; i < 5; i++) cyc(1, MAXC, 0);
    chk("R4", "full scale output", int'(smp_out), MAXC);

    // R5/R9: block 100..115 with invalid garbage interleaved -> 107 + 15 = 122
    cur_tag = "R5";
    cyc(0, 0, 1);
    for (int i = 0; i < 16; i++) begin
      cyc(0, (i % 2 == 0) ? MAXC : 0, 0);
      cyc(1, 100 + i, 0);
    end
    cyc(0, 0, 0);
    chk("R5", "derived threshold", int'(thr_level), 122);
    chk("R9", "invalid samples excluded", int'(thr_level), 122);

    // R6: recalc mid-block ignored, threshold held
    cur_tag = "R6";
    cyc(0, 0, 1);
    for (int i = 0; i < 6; i++) cyc(1, 200, 0);
    cyc(1, 200, 1);
    cyc(0, 0, 1);
    chk("R6", "held while gathering", int'(thr_level), 122);
    for (int i = 0; i < 8; i++) cyc(1, 216, 0);
    chk("R6", "held before 16th", int'(thr_level), 122);
    cyc(1, 216, 0);
    cyc(0, 0, 0);
    // 7*200 + 9*216 = 3344 -> 209 + 16 = 225
    chk("R6", "block not restarted", int'(thr_level), 225);

    // R7: saturation
    cur_tag = "R7";
    cyc(0, 0, 1);
    for (int i = 0; i < 16; i++) cyc(1, (i % 2 == 0) ? MAXC : 0, 0);
    cyc(0, 0, 0);
    chk("R7", "saturated threshold", int'(thr_level), MAXC);

    // R8: manual mode
    cur_tag = "R8";
    thr_manual = 14'd1234; thr_sel_manual = 1'b1;
    #1;
    chk("R8", "manual same cycle", int'(thr_level), 1234);
    for (int i = 0; i < 4; i++) cyc(1, 50, 0);
    thr_manual = 14'd77;
    #1;
    chk("R8", "manual follows input", int'(thr_level), 77);
    cyc(0, 0, 0);
    thr_sel_manual = 1'b0;
    #1;
    chk("R8", "derived kept", int'(thr_level), MAXC);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0);

    finish_up();
  end

endmodule